// File: doc/BRIEF.md
# Dual Masked Calendar Alarm Matcher

This block watches a running calendar time, held as BCD seconds, minutes, hours, date, month and day-of-week, and compares it against two independent alarm register sets. Every alarm field byte carries its own compare-enable in its top bit. Only fields whose enable is set take part, so an alarm can fire every minute, once a day, on one weekday only, and so on. An alarm register set with no enabled field never fires. The alarm year register is not an input of the block, so the year never takes part in a match.

The compare is evaluated only on a one-cycle, once-per-second tick strobe from the time counter. A hit sets that alarm's sticky flag. The flag stays set until software pulses the matching clear input. A level interrupt is raised while any flag is set together with its interrupt enable. The time counter and the register access logic sit outside the block. The reset is asserted asynchronously and released through an internal two-stage synchronizer.

Top module: `cal_alarm_match`

## Requirements
- R1: While reset is asserted, and until the first tick after reset, both flags and the interrupt are 0.
- R2: Each alarm port packs six bytes, from byte 0 upward: seconds, minutes, hours, date, month, day-of-week. Bit 7 of each byte is that field's compare enable. Bits 6:0 hold the BCD value, and the current field is zero-extended to 7 bits for the compare.
- R3: On a cycle with `tick` high, an alarm whose enabled fields all equal the current time sets its flag from the next cycle on.
- R4: A field whose enable bit is 0 does not affect the match, whatever its value.
- R5: Without `tick`, no flag is set, even when the alarm matches.
- R6: An alarm with all six enables at 0 never sets its flag.
- R7: A set flag stays set while its `flag_clr` bit is 0, including after the time stops matching. A `flag_clr` bit high without a set from the same cycle clears that flag in the next cycle.
- R8: If a clear and a set of the same flag occur in the same cycle, the flag is 1 afterwards.
- R9: `irq` equals (flag[0] AND irq_en[0]) OR (flag[1] AND irq_en[1]) as a combinational level. Flag bit 0 belongs to alarm 0 and bit 1 to alarm 1.
- R10: The two alarms are independent: stimulus on one alarm's registers or clear bit never changes the other alarm's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe, once per second |
| cur_sec | input | 7 | Current seconds, BCD 00-59 |
| cur_min | input | 7 | Current minutes, BCD 00-59 |
| cur_hour | input | 6 | Current hours, 24-hour BCD 00-23 |
| cur_date | input | 6 | Current day of month, BCD 01-31 |
| cur_month | input | 5 | Current month, BCD 01-12 |
| cur_dow | input | 3 | Current day of week, 0-6 |
| alm0_regs | input | 48 | Alarm 0 field bytes, packed as in R2 |
| alm1_regs | input | 48 | Alarm 1 field bytes, packed as in R2 |
| irq_en | input | 2 | Interrupt enable per alarm |
| flag_clr | input | 2 | Clear pulse per alarm flag |
| flag | output | 2 | Sticky alarm flags |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach is a partial mask in which a field that differs from the time is disabled while every enabled field is equal. A single mismatching field flips the result only when its enable bit is set. The stimulus therefore sweeps all 64 enable masks against all 64 patterns of fields that differ by one BCD bit, for each alarm, with a fresh time and a clear before each trial. The expected flag is computed as "mask nonzero and mask AND difference equal to zero". The collision of a clear and a set in the same cycle is reached by holding `flag_clr` high on the tick cycle itself.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int NUM_ALARMS  = 2;
  localparam int NUM_FIELDS  = 6;
  localparam int BYTE_W      = 8;
  localparam int VAL_W       = BYTE_W - 1;
  localparam int EN_BIT      = BYTE_W - 1;
  localparam int REGS_W      = NUM_FIELDS * BYTE_W;
  localparam int CUR_W       = NUM_FIELDS * VAL_W;
  localparam int SEC_W       = 7;
  localparam int MIN_W       = 7;
  localparam int HOUR_W      = 6;
  localparam int DATE_W      = 6;
  localparam int MONTH_W     = 5;
  localparam int DOW_W       = 3;
  localparam int SYNC_STAGES = 2;

  typedef enum logic [2:0] {
    FLD_SEC   = 3'd0,
    FLD_MIN   = 3'd1,
    FLD_HOUR  = 3'd2,
    FLD_DATE  = 3'd3,
    FLD_MONTH = 3'd4,
    FLD_DOW   = 3'd5
  } field_e;
endpackage

// File: rtl/cal_rst_sync.sv
module cal_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/cal_field_cmp.sv
module cal_field_cmp #(
  parameter int W = 7
) (
  input  logic [W-1:0] cur_val,
  input  logic [W-1:0] alm_val,
  input  logic         alm_en,
  output logic         field_en,
  output logic         field_ok
);
  always_comb begin
    field_en = alm_en;
    field_ok = !alm_en || (alm_val == cur_val);
  end
endmodule

// File: rtl/cal_alarm_unit.sv
module cal_alarm_unit
  import cal_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [CUR_W-1:0]  cur_vec,
  input  logic [REGS_W-1:0] alm_regs,
  input  logic              clr,
  output logic              flag
);
  logic [NUM_FIELDS-1:0] en_vec;
  logic [NUM_FIELDS-1:0] ok_vec;
  logic                  hit;
  logic                  flag_q;
  logic                  flag_d;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    cal_field_cmp #(.W(VAL_W)) u_cmp (
      .cur_val  (cur_vec[f*VAL_W +: VAL_W]),
      .alm_val  (alm_regs[f*BYTE_W +: VAL_W]),
      .alm_en   (alm_regs[f*BYTE_W + EN_BIT]),
      .field_en (en_vec[f]),
      .field_ok (ok_vec[f])
    );
  end

  always_comb begin
    hit    = (|en_vec) && (&ok_vec);
    flag_d = flag_q;
    if (clr)        flag_d = 1'b0;
    if (tick && hit) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

  AST_SET_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(tick && (|en_vec))); // R5
  AST_NO_ENABLE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && en_vec == '0) |=> !flag_q); // R6
  AST_STICKY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q); // R7
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !tick) |=> !flag_q); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && hit) |=> flag_q); // R8
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
  import cal_alarm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic [SEC_W-1:0]      cur_sec,
  input  logic [MIN_W-1:0]      cur_min,
  input  logic [HOUR_W-1:0]     cur_hour,
  input  logic [DATE_W-1:0]     cur_date,
  input  logic [MONTH_W-1:0]    cur_month,
  input  logic [DOW_W-1:0]      cur_dow,
  input  logic [REGS_W-1:0]     alm0_regs,
  input  logic [REGS_W-1:0]     alm1_regs,
  input  logic [NUM_ALARMS-1:0] irq_en,
  input  logic [NUM_ALARMS-1:0] flag_clr,
  output logic [NUM_ALARMS-1:0] flag,
  output logic                  irq
);
  logic                  rst_n_sync;
  logic [CUR_W-1:0]      cur_vec;
  logic [REGS_W-1:0]     regs_arr [NUM_ALARMS];

  cal_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  always_comb begin
    cur_vec = '0;
    cur_vec[FLD_SEC*VAL_W   +: VAL_W] = VAL_W'(cur_sec);
    cur_vec[FLD_MIN*VAL_W   +: VAL_W] = VAL_W'(cur_min);
    cur_vec[FLD_HOUR*VAL_W  +: VAL_W] = VAL_W'(cur_hour);
    cur_vec[FLD_DATE*VAL_W  +: VAL_W] = VAL_W'(cur_date);
    cur_vec[FLD_MONTH*VAL_W +: VAL_W] = VAL_W'(cur_month);
    cur_vec[FLD_DOW*VAL_W   +: VAL_W] = VAL_W'(cur_dow);
  end

  assign regs_arr[0] = alm0_regs;
  assign regs_arr[1] = alm1_regs;

  for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_alarm
    cal_alarm_unit u_unit (
      .clk      (clk),
      .rst_n    (rst_n_sync),
      .tick     (tick),
      .cur_vec  (cur_vec),
      .alm_regs (regs_arr[a]),
      .clr      (flag_clr[a]),
      .flag     (flag[a])
    );
  end

  always_comb begin
    irq = |(flag & irq_en);
  end

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n_sync)
    irq |-> (flag != '0)); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (irq_en == '0) |-> !irq); // R9
  AST_CLEAR_ONE_ONLY: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (flag_clr == 2'b01 && flag[1] && !tick) |=> flag[1]); // R10
endmodule

// File: tb/cal_alarm_match_tb.sv
module cal_alarm_match_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick;
  logic [6:0]  cur_sec, cur_min;
  logic [5:0]  cur_hour, cur_date;
  logic [4:0]  cur_month;
  logic [2:0]  cur_dow;
  logic [47:0] alm0_regs, alm1_regs;
  logic [1:0]  irq_en, flag_clr, flag;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  logic [6:0] curf [6];

  always #10 clk = ~clk;

  cal_alarm_match u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_date(cur_date), .cur_month(cur_month), .cur_dow(cur_dow),
    .alm0_regs(alm0_regs), .alm1_regs(alm1_regs),
    .irq_en(irq_en), .flag_clr(flag_clr), .flag(flag), .irq(irq)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [6:0] bcd(int v);
    return 7'(((v / 10) << 4) | (v % 10));
  endfunction

  task automatic set_time(int k);
    curf[0] = bcd(k % 60);
    curf[1] = bcd((k * 7) % 60);
    curf[2] = bcd(k % 24);
    curf[3] = bcd(k % 31 + 1);
    curf[4] = bcd(k % 12 + 1);
    curf[5] = 7'(k % 7);
    cur_sec = curf[0]; cur_min = curf[1]; cur_hour = curf[2][5:0];
    cur_date = curf[3][5:0]; cur_month = curf[4][4:0]; cur_dow = curf[5][2:0];
  endtask

  // byte f: bit7 = enable, bits 6:0 = value (differs by bit 0 when diff[f])
  function automatic logic [47:0] make_alarm(logic [5:0] mask, logic [5:0] diff);
    logic [47:0] r;
    for (int f = 0; f < 6; f++)
      r[f*8 +: 8] = {mask[f], curf[f] ^ {6'd0, diff[f]}};
    return r;
  endfunction

  function automatic logic exp_irq(logic [1:0] fl, logic [1:0] en);
    return (fl[0] & en[0]) | (fl[1] & en[1]);
  endfunction

  // clear both flags, then one tick; result checked one edge later
  task automatic trial(int a, int k, logic [5:0] mask, logic [5:0] diff, logic [1:0] en);
    logic e;
    @(negedge clk);
    set_time(k);
    if (a == 0) begin alm0_regs = make_alarm(mask, diff); alm1_regs = '0; end
    else        begin alm1_regs = make_alarm(mask, diff); alm0_regs = '0; end
    irq_en = en; flag_clr = 2'b11; tick = 1'b0;
    @(negedge clk);
    flag_clr = 2'b00; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    e = (mask != 0) && ((mask & diff) == 0);
    if (a == 0) begin
      check("R3/R4/R6 alarm0 flag", 8'(flag[0]), 8'(e));
      check("R10 alarm1 untouched", 8'(flag[1]), 8'd0);
    end else begin
      check("R3/R4/R6 alarm1 flag", 8'(flag[1]), 8'(e));
      check("R10 alarm0 untouched", 8'(flag[0]), 8'd0);
    end
    check("R9 irq level", 8'(irq), 8'(exp_irq(flag, en)));
  endtask

  initial begin
    #3_000_000;
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; flag_clr = '0; irq_en = 2'b11;
    set_time(5);
    alm0_regs = make_alarm(6'h3F, 6'h00);
    alm1_regs = make_alarm(6'h3F, 6'h00);
    repeat (3) @(negedge clk);
    check("R1 flags in reset", 8'(flag), 8'd0);
    check("R1 irq in reset", 8'(irq), 8'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 flags after reset", 8'(flag), 8'd0);

    // R5: matching but no tick
    repeat (5) @(negedge clk);
    check("R5 no tick no flag", 8'(flag), 8'd0);

    // R2/R3/R4/R6: sweep mask x diff for each alarm
    for (int a = 0; a < 2; a++)
      for (int k = 0; k < 4096; k++)
        trial(a, k + a * 13, k[5:0], k[11:6], {k[2], k[1]});

    // R7: sticky after time moves, then clear
    trial(0, 40, 6'h3F, 6'h00, 2'b01);
    @(negedge clk); set_time(41);
    repeat (3) begin @(negedge clk); tick = 1'b1; end
    @(negedge clk); tick = 1'b0;
    check("R7 sticky after mismatch", 8'(flag[0]), 8'd1);
    check("R9 irq while flag set", 8'(irq), 8'd1);
    irq_en = 2'b10; #1;
    check("R9 irq follows enable", 8'(irq), 8'd0);
    irq_en = 2'b01;
    flag_clr = 2'b10;
    @(negedge clk); flag_clr = 2'b00;
    check("R10 clear of other alarm", 8'(flag[0]), 8'd1);
    flag_clr = 2'b01;
    @(negedge clk); flag_clr = 2'b00;
    check("R7 clear takes effect", 8'(flag[0]), 8'd0);
    check("R9 irq drops with flag", 8'(irq), 8'd0);

    // R8: clear and set in same cycle
    set_time(41); alm0_regs = make_alarm(6'h05, 6'h3A);
    flag_clr = 2'b01; tick = 1'b1;
    @(negedge clk); flag_clr = 2'b00; tick = 1'b0;
    check("R8 set wins over clear", 8'(flag[0]), 8'd1);

    // R2: hour byte only, matching value in bits 6:0
    flag_clr = 2'b11; @(negedge clk); flag_clr = 2'b00;
    set_time(23); alm0_regs = '0; alm0_regs[23:16] = {1'b1, bcd(23)};
    tick = 1'b1; @(negedge clk); tick = 1'b0;
    check("R2 hour byte position", 8'(flag[0]), 8'd1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule